// File: doc/BRIEF.md
# Manchester Line Encoder with Programmable Lead-In

This block sends one byte at a time on a single serial wire using Manchester coding. A byte is handed over with a valid/ready handshake, together with a configuration word. The configuration word gives the length of an optional lead-in sequence, the bit pattern of that lead-in, and the transition direction that stands for each logic value. Once the block has taken a byte, it sends the lead-in bits, then one start bit of logic zero, then the data bits with the least significant bit first. After that the wire goes back to its idle level.

Timing comes from an external divider that pulses `halfTick` for one clock at twice the bit rate. Each pulse ends one half-bit interval, so the wire can change only at those pulses. The lead-in bits use the same polarity as the data bits. The configuration and the data are captured once, at acceptance. Any change to them while a frame is on the wire applies only to a later frame.

Top module: `manchester_tx`

## Requirements
- R1: After reset, and in every cycle in which `inReady` is high, `serOut` is at the idle level (1 by default). Reset leaves `inReady` high.
- R2: A byte is accepted at a clock edge where `inValid` and `inReady` are both high. `inReady` is low from the next cycle onward and `inValid` is ignored during that time. The `halfTick` pulse that follows the final half-bit returns `serOut` to idle, and `inReady` rises at that same edge.
- R3: `serOut` changes only at clock edges where `halfTick` is high. Each such pulse during a frame drives the next half-bit.
- R4: A frame is the lead-in bits, then one start bit of logic 0, then the 8 data bits LSB first, for 2*(L+9) half-bits in total, where L is the lead-in length.
- R5: With the length field `cfgWord[3:0]` at 0 there is no lead-in, and the first half-bit belongs to the start bit.
- R6: A length field L from 1 to 15 gives a lead-in of exactly L bit periods.
- R7: The pattern field `cfgWord[5:4]` selects the lead-in bits: 00 all ones, 01 all zeros, 10 the sequence 0,1,0,1,... and 11 the sequence 1,0,1,0,... The sequence restarts with each frame.
- R8: With the polarity bit `cfgWord[6]` at 0, a logic 0 is sent as low then high, and a logic 1 as high then low.
- R9: With `cfgWord[6]` at 1 both mappings are swapped, for the lead-in bits as well as for the start and data bits.
- R10: `inData` and `cfgWord` are sampled only at acceptance. Changing them during a frame does not alter that frame.
- R11: A `halfTick` pulse in the acceptance cycle is ignored. The first half-bit is driven at the first pulse after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | One-cycle pulse at twice the bit rate |
| inData | input | 8 | Byte to send |
| inValid | input | 1 | Byte and configuration are offered |
| inReady | output | 1 | Block can accept a byte |
| cfgWord | input | 7 | [3:0] lead-in length, [5:4] pattern, [6] polarity |
| serOut | output | 1 | Manchester-coded serial line |

## Verification
Every line result becomes visible at the clock edge of the `halfTick` pulse that produced it. The half-bit for the n-th pulse after acceptance appears at that pulse's edge, and the idle level and `inReady` return at pulse 2*(L+9)+1. The bench computes the full half-bit list for each frame and queues it. A monitor pops one entry for every pulse and samples at the following falling edge. On the falling edges between pulses it checks that the line has not moved. `inReady` is sampled one falling edge after acceptance and one after the final pulse, and some frames are launched on purpose so that a pulse coincides with acceptance.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_START,
    PH_DATA,
    PH_TAIL
  } phase_e;

  // strobes from the sequencer to the line datapath
  typedef struct packed {
    logic   load;        // capture byte and configuration
    logic   drive;       // put the current half-bit on the line
    logic   shift;       // move to the next data bit
    logic   goIdle;      // return the line to idle
    phase_e phase;       // which part of the frame is being sent
    logic   secondHalf;  // 0: first half of the bit, 1: second half
    logic   preOdd;      // odd-numbered lead-in bit
  } strobe_t;

endpackage

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             inValid,
  input  logic [LEN_W-1:0] cfgLen,
  output logic             inReady,
  output strobe_t          st
);

  localparam int DCNT_W = $clog2(DATA_W);
  localparam int CNT_W  = (LEN_W > DCNT_W) ? LEN_W : DCNT_W;
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  phase_e           state;
  logic [CNT_W-1:0] bitCnt;
  logic             half;
  logic [LEN_W-1:0] preLen;
  logic [CNT_W-1:0] lastPre;
  logic             busyTick;

  assign lastPre = CNT_W'(preLen) - CNT_W'(1);
  assign inReady = (state == PH_IDLE);

  always_comb begin
    busyTick = halfTick &&
               ((state == PH_PRE) || (state == PH_START) || (state == PH_DATA));
    st            = '0;
    st.phase      = state;
    st.secondHalf = half;
    st.preOdd     = bitCnt[0];
    st.load       = (state == PH_IDLE) && inValid;
    st.drive      = busyTick;
    st.shift      = busyTick && (state == PH_DATA) && half;
    st.goIdle     = halfTick && (state == PH_TAIL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      bitCnt <= '0;
      half   <= 1'b0;
      preLen <= '0;
    end else if (st.load) begin
      preLen <= cfgLen;
      bitCnt <= '0;
      half   <= 1'b0;
      state  <= (cfgLen == '0) ? PH_START : PH_PRE;
    end else if (st.goIdle) begin
      state <= PH_IDLE;
    end else if (st.drive) begin
      half <= ~half;
      if (half) begin
        bitCnt <= bitCnt + CNT_W'(1);
        unique case (state)
          PH_PRE: begin
            if (bitCnt == lastPre) begin
              state  <= PH_START;
              bitCnt <= '0;
            end
          end
          PH_START: begin
            state  <= PH_DATA;
            bitCnt <= '0;
          end
          PH_DATA: begin
            if (bitCnt == LAST_DATA) state <= PH_TAIL;
          end
          default: state <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mtx_datapath.sv
module mtx_datapath
  import mtx_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        cfgPat,
  input  logic              cfgPol,
  output logic              serOut
);

  logic [DATA_W-1:0] shReg;
  logic [1:0]        patQ;
  logic              polQ;
  logic              lineQ;
  logic              logicBit;
  logic              level;

  // logic value of the bit currently being sent
  always_comb begin
    unique case (st.phase)
      PH_PRE: begin
        unique case (patQ)
          2'b00:   logicBit = 1'b1;
          2'b01:   logicBit = 1'b0;
          2'b10:   logicBit = st.preOdd;
          default: logicBit = ~st.preOdd;
        endcase
      end
      PH_DATA: logicBit = shReg[0];
      default: logicBit = 1'b0;
    endcase
    level = logicBit ^ polQ ^ st.secondHalf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      patQ  <= 2'b00;
      polQ  <= 1'b0;
      lineQ <= IDLE_LEVEL;
    end else begin
      if (st.load) begin
        shReg <= inData;
        patQ  <= cfgPat;
        polQ  <= cfgPol;
      end else if (st.shift) begin
        shReg <= shReg >> 1;
      end
      if (st.drive)       lineQ <= level;
      else if (st.goIdle) lineQ <= IDLE_LEVEL;
    end
  end

  assign serOut = lineQ;

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter int   LEN_W      = 4,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [LEN_W+2:0]  cfgWord,
  output logic              serOut
);

  strobe_t stb;

  mtx_ctrl #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .halfTick(halfTick),
    .inValid (inValid),
    .cfgLen  (cfgWord[LEN_W-1:0]),
    .inReady (inReady),
    .st      (stb)
  );

  mtx_datapath #(
    .DATA_W    (DATA_W),
    .IDLE_LEVEL(IDLE_LEVEL)
  ) uPath (
    .clk   (clk),
    .rstN  (rstN),
    .st    (stb),
    .inData(inData),
    .cfgPat(cfgWord[LEN_W+1:LEN_W]),
    .cfgPol(cfgWord[LEN_W+2]),
    .serOut(serOut)
  );

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic halfTick,
  input logic inValid,
  input logic inReady,
  input logic serOut
);

  logic par;
  logic capFirst;
  logic capSecond;
  logic firstVal;

  // follows the half-bit parity of the line to check the mid-bit flip
  always_ff @(posedge clk) begin
    if (!rstN) begin
      par       <= 1'b0;
      capFirst  <= 1'b0;
      capSecond <= 1'b0;
      firstVal  <= IDLE_LEVEL;
    end else begin
      capFirst  <= halfTick && !inReady && !par;
      capSecond <= halfTick && !inReady && par;
      if (inValid && inReady)        par <= 1'b0;
      else if (halfTick && !inReady) par <= ~par;
      if (capFirst) firstVal <= serOut;
    end
  end

  AST_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> serOut == IDLE_LEVEL); // R1

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady); // R2

  AST_HALF_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !halfTick |=> $stable(serOut)); // R3

  AST_MID_BIT_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    capSecond |-> serOut != firstVal); // R8

  AST_ACCEPT_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> $stable(serOut)); // R11

endmodule

bind manchester_tx mtx_checker #(.IDLE_LEVEL(IDLE_LEVEL)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .halfTick(halfTick),
  .inValid (inValid),
  .inReady (inReady),
  .serOut  (serOut)
);

// File: tb/manchester_tx_test.sv
module manchester_tx_test;

  localparam int TICK_DIV = 3;
  localparam bit IDLE = 1'b1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [6:0] cfgWord = '0;
  logic       serOut;

  int    checks = 0;
  int    fails = 0;
  bit    monOn = 1'b0;
  bit    tickEn = 1'b0;
  bit    finished = 1'b0;
  int    tickCnt = 0;
  bit    lastLine = 1'b1;
  bit    lvlQ[$];
  string tagQ[$];

  manchester_tx uut (
    .clk     (clk),
    .rstN    (rstN),
    .halfTick(halfTick),
    .inData  (inData),
    .inValid (inValid),
    .inReady (inReady),
    .cfgWord (cfgWord),
    .serOut  (serOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: one queued half-bit per tick pulse, stability in between
  always @(negedge clk) begin
    if (monOn) begin
      if (halfTick) begin
        bit    e;
        string t;
        e = IDLE;
        t = "R1";
        if (lvlQ.size() != 0) begin
          e = lvlQ.pop_front();
          t = tagQ.pop_front();
        end
        chk(serOut == e, t, "line at tick", int'(serOut), int'(e));
      end else begin
        chk(serOut == lastLine, "R3", "line moved without tick",
            int'(serOut), int'(lastLine));
      end
    end
    lastLine = serOut;
    tickCnt = (tickCnt + 1) % TICK_DIV;
    halfTick = tickEn && (tickCnt == TICK_DIV - 1);
  end

  task automatic pushBit(input bit b, input bit pol, input string tag);
    lvlQ.push_back(b ^ pol);
    tagQ.push_back(tag);
    lvlQ.push_back(~(b ^ pol));
    tagQ.push_back(tag);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic [6:0] cfg,
                           input bit wantTick, input string preTag,
                           input string dataTag);
    int len;
    bit pol;
    bit b;
    len = int'(cfg[3:0]);
    pol = cfg[6];
    @(negedge clk);
    #1;
    while (!inReady || (wantTick && !halfTick)) begin
      @(negedge clk);
      #1;
    end
    inData  = d;
    cfgWord = cfg;
    inValid = 1'b1;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inData  = ~d;      // R10: disturb inputs during the frame
    cfgWord = ~cfg;
    if (halfTick) begin
      lvlQ.push_back(IDLE);
      tagQ.push_back("R11");
    end
    for (int k = 0; k < len; k++) begin
      case (cfg[5:4])
        2'b00:   b = 1'b1;
        2'b01:   b = 1'b0;
        2'b10:   b = k[0];
        default: b = ~k[0];
      endcase
      pushBit(b, pol, preTag);
    end
    pushBit(1'b0, pol, (len == 0) ? "R5" : "R4");
    for (int i = 0; i < 8; i++) pushBit(d[i], pol, dataTag);
    lvlQ.push_back(IDLE);
    tagQ.push_back("R2");
    @(negedge clk);
    #1;
    chk(inReady == 1'b0, "R2", "ready after accept", int'(inReady), 0);
    while (lvlQ.size() != 0) @(negedge clk);
    @(negedge clk);
    #1;
    chk(inReady == 1'b1, "R2", "ready after frame", int'(inReady), 1);
    chk(serOut == IDLE, "R1", "idle after frame", int'(serOut), int'(IDLE));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(serOut == IDLE, "R1", "reset line", int'(serOut), int'(IDLE));
    chk(inReady == 1'b1, "R1", "reset ready", int'(inReady), 1);
    rstN = 1'b1;
    tickEn = 1'b1;
    monOn = 1'b1;
    sendFrame(8'hA5, {1'b0, 2'b00, 4'd0},  1'b0, "R5", "R8");
    sendFrame(8'h3C, {1'b0, 2'b00, 4'd1},  1'b0, "R6", "R8");
    sendFrame(8'hF0, {1'b1, 2'b01, 4'd4},  1'b0, "R7", "R9");
    sendFrame(8'h5A, {1'b0, 2'b10, 4'd5},  1'b0, "R7", "R8");
    sendFrame(8'h81, {1'b1, 2'b11, 4'd15}, 1'b0, "R6", "R9");
    sendFrame(8'h00, {1'b1, 2'b10, 4'd3},  1'b1, "R9", "R10");
    sendFrame(8'hFF, {1'b0, 2'b11, 4'd2},  1'b1, "R7", "R10");
    sendFrame(8'h6E, {1'b1, 2'b00, 4'd0},  1'b0, "R5", "R9");
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule